// File: doc/BRIEF.md
# Multiplier Busy Interlock Controller

This block decides when the instruction held in the decode (ID) stage of a five-stage in-order pipeline may advance, in a pipeline where several instruction classes share one multi-cycle multiplier. Each cycle it receives the decoded class code of the instruction in ID and a valid flag. It also receives a fetch-request line that shows when instruction fetch wants the shared bus. It follows any double-length multiply-accumulate through its execute slot and its two memory-access slots, and then through the multiplier busy window that follows.

The instruction in ID is presented as a stream. `id_valid` is the producer's valid, and `id_stall` is the inverse of ready. An instruction leaves ID on a rising edge where `id_valid` is high and `id_stall` is low. While `id_stall` is high, the producer must keep `id_valid` and `id_class` stable. `fetch_req`, `if_hold` and `mul_start` are plain control pins. When `if_hold` is high, the fetch unit must not use the bus in that cycle and retries in the next cycle.

The accumulate uses the bus in both of its memory slots, and those slots take priority over fetch. The multiplier is started in the second memory slot. It then stays busy for a fixed number of cycles, whether or not those cycles line up with slot boundaries.

Top module: `mbi_interlock`

## Requirements
- R1: After a synchronous reset, `if_hold` and `mul_start` are low and the busy counter is clear. A multiplier-class instruction presented right after reset leaves ID with zero stall cycles.
- R2: The class codes are 4 bits wide:
  - 1: double-length accumulate
  - 2: word accumulate
  - 3: double-length signed multiply
  - 4: word signed multiply
  - 5: result-register-to-general-register move
  - 6: result-register store to memory
  - 7: general-register-to-result-register load
  - 8: result-register load from memory
  - 1 to 8 are the multiplier classes. Code 0 and codes 9 to 15 are non-multiplier classes.
- R3: In the cycle right after a double-length accumulate leaves ID, `id_stall` is high for any valid instruction in ID.
- R4: If a double-length accumulate leaves ID in cycle t, it is in EX in cycle t+1 and in its memory slots in cycles t+2 and t+3. `mul_start` is high in cycle t+3 only.
- R5: A multiplier-class instruction in ID is held while an accumulate is in EX or in a memory slot, and while more than one busy cycle remains. With NUM_MA=2 and BUSY_CYCLES=4, a multiplier-class instruction directly after the accumulate stalls exactly 6 cycles.
- R6: A non-multiplier instruction directly after the accumulate stalls exactly 1 cycle. The non-multiplier instruction after it stalls 0 cycles.
- R7: `if_hold` equals `fetch_req` in both memory slots of an accumulate (cycles t+2 and t+3). `if_hold` is low in every other cycle.
- R8: `id_stall` is low whenever `id_valid` is low.
- R9: A multiplier-class instruction that reaches ID after a non-multiplier instruction has already slipped past the accumulate still waits for release. It stalls exactly 4 cycles with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| id_valid | input | 1 | An instruction is present in ID |
| id_class | input | 4 | Decoded class code of the instruction in ID |
| fetch_req | input | 1 | Instruction fetch wants the bus in this cycle |
| id_stall | output | 1 | Hold the instruction in ID (inverse of ready) |
| if_hold | output | 1 | Fetch loses the bus to a memory slot of an accumulate |
| mul_start | output | 1 | One-cycle strobe that starts the multiplier |

## Verification
The bench counts stall cycles for the following cases and compares each count with a closed-form model built from NUM_MA and BUSY_CYCLES:
- back-to-back accumulates;
- an accumulate followed by each of the seven other multiplier classes;
- an accumulate followed by each non-multiplier code;
- a multiplier instruction arriving late in the busy window.

An off-by-one in the release point would show up as a count of 5 or 7 where 6 is expected. A decoder that misses a class would give 1 where 6 is expected. Leaving the late arrival out of the interlock would give 0 where 4 is expected.

The fetch-collision case checks that fetch loses the bus in exactly the two memory slots. It also checks that the multiplier strobe fires once, in the second slot, rather than in the first slot or for two cycles.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
  localparam int CLASS_W = 4;

  typedef enum logic [CLASS_W-1:0] {
    CL_OTHER   = 4'd0,
    CL_ACC_L   = 4'd1,
    CL_ACC_W   = 4'd2,
    CL_DMUL_L  = 4'd3,
    CL_MUL_W   = 4'd4,
    CL_RES2GPR = 4'd5,
    CL_RES2MEM = 4'd6,
    CL_GPR2RES = 4'd7,
    CL_MEM2RES = 4'd8
  } iclass_e;

  function automatic logic is_mul_class(input logic [CLASS_W-1:0] c);
    return (c >= CL_ACC_L) && (c <= CL_MEM2RES);
  endfunction
endpackage

// File: rtl/mbi_decode.sv
module mbi_decode
  import mbi_pkg::*;
(
  input  logic               vld,
  input  logic [CLASS_W-1:0] cls,
  output logic               acc_l,
  output logic               mul_user
);
  always_comb begin
    acc_l    = vld && (cls == CL_ACC_L);
    mul_user = vld && is_mul_class(cls);
  end
endmodule

// File: rtl/mbi_tracker.sv
module mbi_tracker #(
  parameter int NUM_MA      = 2,
  parameter int BUSY_CYCLES = 4,
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_issue,
  output logic [NUM_MA:0]  stg,
  output logic [CNT_W-1:0] busy_cnt,
  output logic             start
);
  // stg[0] = EX slot, stg[1..NUM_MA] = memory slots of the accumulate
  always_ff @(posedge clk) begin
    if (rst) stg[0] <= 1'b0;
    else     stg[0] <= acc_issue;
  end

  for (genvar g = 1; g <= NUM_MA; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= 1'b0;
      else     stg[g] <= stg[g-1];
    end
  end

  assign start = stg[NUM_MA];

  always_ff @(posedge clk) begin
    if (rst)                     busy_cnt <= '0;
    else if (stg[NUM_MA])        busy_cnt <= CNT_W'(BUSY_CYCLES);
    else if (busy_cnt != '0)     busy_cnt <= busy_cnt - CNT_W'(1);
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    start |=> !start); // R4
  AST_ONE_ACC_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stg)); // R5
endmodule

// File: rtl/mbi_stall_ctrl.sv
module mbi_stall_ctrl #(
  parameter int NUM_MA = 2,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             id_valid,
  input  logic             mul_user,
  input  logic             fetch_req,
  input  logic [NUM_MA:0]  stg,
  input  logic [CNT_W-1:0] busy_cnt,
  output logic             id_stall,
  output logic             if_hold
);
  logic follow_slot, mul_busy, ma_active;

  always_comb begin
    follow_slot = stg[0];
    ma_active   = |stg[NUM_MA:1];
    // released in the cycle where the last busy cycle runs out
    mul_busy    = (|stg) || (busy_cnt > CNT_W'(1));
    id_stall    = id_valid && (follow_slot || (mul_user && mul_busy));
    if_hold     = fetch_req && ma_active;
  end

  AST_IFHOLD_QUAL: assert property (@(posedge clk) disable iff (rst)
    if_hold |-> fetch_req); // R7
endmodule

// File: rtl/mbi_interlock.sv
module mbi_interlock
  import mbi_pkg::*;
#(
  parameter int NUM_MA      = 2,
  parameter int BUSY_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               id_valid,
  input  logic [CLASS_W-1:0] id_class,
  input  logic               fetch_req,
  output logic               id_stall,
  output logic               if_hold,
  output logic               mul_start
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic             acc_l, mul_user, acc_issue;
  logic [NUM_MA:0]  stg;
  logic [CNT_W-1:0] busy_cnt;

  mbi_decode u_dec (
    .vld(id_valid), .cls(id_class), .acc_l(acc_l), .mul_user(mul_user)
  );

  assign acc_issue = acc_l && !id_stall;

  mbi_tracker #(.NUM_MA(NUM_MA), .BUSY_CYCLES(BUSY_CYCLES)) u_trk (
    .clk(clk), .rst(rst), .acc_issue(acc_issue),
    .stg(stg), .busy_cnt(busy_cnt), .start(mul_start)
  );

  mbi_stall_ctrl #(.NUM_MA(NUM_MA), .CNT_W(CNT_W)) u_stl (
    .clk(clk), .rst(rst), .id_valid(id_valid), .mul_user(mul_user),
    .fetch_req(fetch_req), .stg(stg), .busy_cnt(busy_cnt),
    .id_stall(id_stall), .if_hold(if_hold)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!mul_start && !if_hold)); // R1
  AST_FOLLOW_STALL: assert property (@(posedge clk) disable iff (rst)
    acc_issue |=> (!id_valid || id_stall)); // R3
  AST_MUL_WAIT: assert property (@(posedge clk) disable iff (rst)
    (mul_start && mul_user) |-> id_stall); // R5
endmodule

// File: tb/sim_mbi_interlock.sv
module sim_mbi_interlock;
  localparam int NUM_MA = 2;
  localparam int BUSY   = 4;
  localparam int EXP_MUL_FOLLOW = 1 + NUM_MA + BUSY - 1;   // R5 model
  localparam int EXP_LATE_MUL   = EXP_MUL_FOLLOW - 2;      // R9 model

  logic clk = 1'b0, rst = 1'b1, id_valid = 1'b0, fetch_req = 1'b0;
  logic [3:0] id_class = 4'd0;
  logic id_stall, if_hold, mul_start;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  mbi_interlock #(.NUM_MA(NUM_MA), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_class(id_class),
    .fetch_req(fetch_req), .id_stall(id_stall), .if_hold(if_hold),
    .mul_start(mul_start)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; id_valid = 1'b0; fetch_req = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  // present one instruction in ID, count stall cycles until it leaves
  task automatic issue(input logic [3:0] cls, output int stalls);
    stalls = 0;
    @(negedge clk); id_valid = 1'b1; id_class = cls;
    #1;
    while (id_stall) begin
      stalls++;
      @(negedge clk); #1;
      if (stalls > 50) break;
    end
    @(posedge clk); #0.5;
    id_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic t_reset();
    int s;
    do_reset();
    #1;
    check("R1 mul_start after reset", mul_start, 0);
    check("R1 if_hold after reset", if_hold, 0);
    issue(4'd4, s);
    check("R1 mul class right after reset", s, 0);
    idle(8);
  endtask

  task automatic t_back_to_back();
    int s;
    issue(4'd1, s); check("R5 first accumulate", s, 0);
    issue(4'd1, s); check("R5 back-to-back accumulate", s, EXP_MUL_FOLLOW);
    issue(4'd0, s); check("R6 non-mul after second accumulate", s, 1);
    idle(10);
  endtask

  task automatic t_non_mul();
    int s;
    issue(4'd1, s);
    issue(4'd9, s); check("R6 non-mul follower", s, 1);
    issue(4'd0, s); check("R6 second non-mul", s, 0);
    idle(10);
  endtask

  task automatic t_classes();
    int s;
    for (int c = 2; c <= 8; c++) begin
      issue(4'd1, s);
      issue(4'(c), s);
      check($sformatf("R2 R5 class %0d after accumulate", c), s, EXP_MUL_FOLLOW);
      idle(10);
    end
    for (int c = 9; c <= 15; c++) begin
      issue(4'd1, s);
      issue(4'(c), s);
      check($sformatf("R2 R6 class %0d after accumulate", c), s, 1);
      idle(10);
    end
  endtask

  task automatic t_late_mul();
    int s;
    issue(4'd1, s);
    issue(4'd0, s); check("R9 non-mul slips past", s, 1);
    issue(4'd5, s); check("R9 late multiplier class", s, EXP_LATE_MUL);
    idle(10);
  endtask

  // accumulate with fetch wanting the bus every cycle
  task automatic t_fetch_collide();
    int s;
    fetch_req = 1'b1;
    issue(4'd1, s);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk); #1;
      if (k == 1) check("R8 no stall without valid", id_stall, 0);
      check($sformatf("R7 if_hold cycle t+%0d", k), if_hold, (k == 2 || k == 3) ? 1 : 0);
      check($sformatf("R4 mul_start cycle t+%0d", k), mul_start, (k == 3) ? 1 : 0);
    end
    fetch_req = 1'b0;
    idle(6);
  endtask

  // R3: stall present in the slot right after the accumulate leaves ID
  task automatic t_follow_slot();
    int s;
    issue(4'd1, s);
    @(negedge clk); id_valid = 1'b1; id_class = 4'd12; #1;
    check("R3 follow-slot stall", id_stall, 1);
    @(posedge clk); @(negedge clk); #1;
    check("R3 released after one slot", id_stall, 0);
    @(posedge clk); #0.5; id_valid = 1'b0;
    idle(8);
  endtask

  initial begin
    t_reset();
    t_back_to_back();
    t_non_mul();
    t_classes();
    t_late_mul();
    t_fetch_collide();
    t_follow_slot();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule